// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block serves one transmit queue of a network interface. Host software places 16-byte descriptors in a ring in host memory and moves a tail index forward. Whenever the head index differs from the latched tail and the queue is enabled, the engine reads the descriptor at the head through a request/response DMA port. It checks the descriptor's type and end-of-frame flag, reads the packet buffer that the descriptor points to, and streams those bytes out of an Ethernet transmit port as one frame.

Every descriptor ends with a completion write, made in one of two modes. In descriptor mode the descriptor is overwritten in place with a done marker. In head-index mode a 4-byte write carries the next ring index to a configured host address. The head moves forward and a one-cycle interrupt request is raised only once that write has been acknowledged. Only one descriptor is in flight at a time. An unsupported descriptor halts the queue in an error state until software disables it.

The state machine has the states IDLE, DESC_REQ, DESC_W0, DESC_W1, CHECK, BUF_REQ, STREAM, WB_REQ, WB_ACK and ERROR. Its transitions are:
- IDLE to DESC_REQ when the queue is enabled and head differs from tail.
- DESC_REQ to DESC_W0 when the request is accepted.
- DESC_W0 to DESC_W1 to CHECK on each read beat.
- CHECK to ERROR on a bad type or a missing end-of-frame flag.
- CHECK to WB_REQ when the size is zero, and to BUF_REQ otherwise.
- BUF_REQ to STREAM when the request is accepted.
- STREAM to WB_REQ on the last transmitted beat.
- WB_REQ to WB_ACK when the write is accepted.
- WB_ACK to IDLE on the write acknowledge.
- ERROR to IDLE when the queue is disabled.

Top module: `txring_engine`

## Requirements
- R1: After reset, the head index is 0 and there is no DMA request, no transmit beat, no interrupt and no error.
- R2: When the queue is enabled and head differs from tail, the engine issues a 16-byte DMA read at ring base + 16 × head. The request holds its address and direction steady until it is accepted.
- R3: If the descriptor type field (second word, bits 3:0) is not the data code 0, the queue enters the error state. It then makes no further requests and does not advance the head.
- R4: If a data descriptor lacks the end-of-frame flag (second word, bit 4), the queue enters the error state.
- R5: For a buffer size S taken from the second word (bits 47:34), the engine reads S bytes from the address in the first word and sends them as one frame of 8-byte beats. Byte k of a beat is at bits 8k+7:8k, and the final beat carries tx_last with a keep mask holding the low (S mod 8, or 8) bits.
- R6: With head-index writeback off, the completion is a 16-byte write to the descriptor's own address. Its data has the first word (wdata 63:0) equal to 0 and the second word (wdata 127:64) equal to the done code 0xF.
- R7: With head-index writeback on, the completion is a 4-byte write to the writeback address. Its data (wdata 31:0) is (index+1) mod ring length, and no descriptor is written.
- R8: The head becomes (index+1) mod ring length only after the completion write is acknowledged, and irq pulses for one cycle at that point.
- R9: Tail writes made while a descriptor is in flight are latched. The engine goes on processing descriptors, wrapping around the ring, until head equals tail.
- R10: While the queue is disabled, no descriptor fetch starts. A completion acknowledge that arrives while the queue is disabled leaves the head unchanged and raises no irq.
- R11: Deasserting the enable clears the error state.
- R12: A data descriptor with size 0 produces no transmit beat and still completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Queue enable |
| cfg_ring_base | input | ADDR_W | Host address of ring entry 0 |
| cfg_ring_len | input | IDX_W | Number of ring entries (nonzero) |
| cfg_hwb_en | input | 1 | Head-index writeback mode select |
| cfg_hwb_addr | input | ADDR_W | Host address for head-index writes |
| tail_wr | input | 1 | Tail update strobe |
| tail_val | input | IDX_W | New tail index |
| head_idx | output | IDX_W | Current head index |
| dma_req_valid | output | 1 | DMA request valid |
| dma_req_ready | input | 1 | DMA request accepted |
| dma_req_write | output | 1 | 1 for a write, 0 for a read |
| dma_req_addr | output | ADDR_W | DMA byte address |
| dma_req_len | output | 16 | DMA length in bytes |
| dma_req_wdata | output | 128 | Write data, lowest byte first |
| dma_rd_valid | input | 1 | Read data beat valid |
| dma_rd_ready | output | 1 | Read data beat accepted |
| dma_rd_data | input | 64 | Read data beat |
| dma_wack_valid | input | 1 | Write acknowledge |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit beat accepted |
| tx_data | output | 64 | Transmit data |
| tx_keep | output | 8 | Valid byte mask |
| tx_last | output | 1 | Final beat of the frame |
| irq | output | 1 | Completion interrupt pulse |
| err | output | 1 | Queue error state |

## Verification
The hardest case to reach is a completion acknowledge that lands while the queue is disabled. The bench watches the DMA request log, and as soon as the completion write has been accepted it drops the enable in that same cycle, before the acknowledge it has scheduled two cycles later. It then re-enables the queue to show that the descriptor is fetched and completed again. Tail latching under load is reached by writing a wrapped tail while a stalled transmit port holds the first frame in flight.

// File: rtl/txr_pkg.sv
package txr_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_DESC_REQ, S_DESC_W0, S_DESC_W1, S_CHECK,
        S_BUF_REQ, S_STREAM, S_WB_REQ, S_WB_ACK, S_ERROR
    } txr_state_e;

    localparam int TYPE_LSB = 0;
    localparam int TYPE_W = 4;
    localparam int EOP_BIT = 4;
    localparam int SIZE_LSB = 34;
    localparam logic [TYPE_W-1:0] TYPE_DATA = 4'h0;
    localparam logic [TYPE_W-1:0] TYPE_DONE = 4'hF;
    localparam int DESC_BYTES = 16;
    localparam int BEAT_BYTES = 8;
    localparam int HWB_BYTES = 4;
endpackage

// File: rtl/txr_desc_decode.sv
module txr_desc_decode
    import txr_pkg::*;
#(
    parameter int SIZE_W = 14
) (
    input  logic [63:0]       word1,
    output logic              is_data,
    output logic              has_eop,
    output logic [SIZE_W-1:0] buf_size
);
    assign is_data  = (word1[TYPE_LSB +: TYPE_W] == TYPE_DATA);
    assign has_eop  = word1[EOP_BIT];
    assign buf_size = word1[SIZE_LSB +: SIZE_W];
endmodule

// File: rtl/txr_idx_next.sv
module txr_idx_next #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] ring_len,
    output logic [IDX_W-1:0] nxt
);
    logic [IDX_W:0] inc;
    assign inc = {1'b0, idx} + 1'b1;
    assign nxt = (inc == {1'b0, ring_len}) ? '0 : inc[IDX_W-1:0];
endmodule

// File: rtl/txr_beat_track.sv
module txr_beat_track #(
    parameter int LEN_W = 14,
    parameter int BEAT_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [LEN_W-1:0]      len,
    input  logic                  beat,
    output logic [BEAT_BYTES-1:0] keep,
    output logic                  last
);
    localparam logic [LEN_W-1:0] STEP = LEN_W'(BEAT_BYTES);
    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rem_q <= '0;
        else if (load)
            rem_q <= len;
        else if (beat)
            rem_q <= (rem_q > STEP) ? rem_q - STEP : '0;
    end

    assign last = (rem_q <= STEP);

    for (genvar i = 0; i < BEAT_BYTES; i++) begin : g_keep
        assign keep[i] = (rem_q > LEN_W'(i));
    end

    // R5: a transmitted beat always has bytes left to carry
    a_r5_beat_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        beat |-> rem_q != '0);
endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txr_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 8,
    parameter int SIZE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic [IDX_W-1:0]  cfg_ring_len,
    input  logic              cfg_hwb_en,
    input  logic [ADDR_W-1:0] cfg_hwb_addr,
    input  logic              tail_wr,
    input  logic [IDX_W-1:0]  tail_val,
    output logic [IDX_W-1:0]  head_idx,
    output logic              dma_req_valid,
    input  logic              dma_req_ready,
    output logic              dma_req_write,
    output logic [ADDR_W-1:0] dma_req_addr,
    output logic [15:0]       dma_req_len,
    output logic [127:0]      dma_req_wdata,
    input  logic              dma_rd_valid,
    output logic              dma_rd_ready,
    input  logic [63:0]       dma_rd_data,
    input  logic              dma_wack_valid,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [63:0]       tx_data,
    output logic [7:0]        tx_keep,
    output logic              tx_last,
    output logic              irq,
    output logic              err
);
    localparam int SLOT_SHIFT = $clog2(DESC_BYTES);

    txr_state_e state_q, state_d;
    logic [IDX_W-1:0]  head_q, tail_q, cur_idx_q, nxt_idx;
    logic [ADDR_W-1:0] desc_addr_q, buf_addr_q;
    logic [63:0]       word1_q;
    logic              is_data, has_eop, irq_q;
    logic [SIZE_W-1:0] buf_size;
    logic              beat_go, beat_last;
    logic [7:0]        beat_keep;

    txr_desc_decode #(.SIZE_W(SIZE_W)) u_dec (
        .word1(word1_q), .is_data(is_data), .has_eop(has_eop), .buf_size(buf_size));

    txr_idx_next #(.IDX_W(IDX_W)) u_nxt (
        .idx(cur_idx_q), .ring_len(cfg_ring_len), .nxt(nxt_idx));

    txr_beat_track #(.LEN_W(SIZE_W), .BEAT_BYTES(BEAT_BYTES)) u_trk (
        .clk(clk), .rst_n(rst_n), .load(state_q == S_CHECK), .len(buf_size),
        .beat(beat_go), .keep(beat_keep), .last(beat_last));

    assign beat_go = (state_q == S_STREAM) && dma_rd_valid && tx_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (cfg_enable && head_q != tail_q) state_d = S_DESC_REQ;
            S_DESC_REQ: if (dma_req_ready) state_d = S_DESC_W0;
            S_DESC_W0:  if (dma_rd_valid) state_d = S_DESC_W1;
            S_DESC_W1:  if (dma_rd_valid) state_d = S_CHECK;
            S_CHECK: begin
                if (!is_data || !has_eop) state_d = S_ERROR;
                else if (buf_size == '0) state_d = S_WB_REQ;
                else state_d = S_BUF_REQ;
            end
            S_BUF_REQ:  if (dma_req_ready) state_d = S_STREAM;
            S_STREAM:   if (beat_go && beat_last) state_d = S_WB_REQ;
            S_WB_REQ:   if (dma_req_ready) state_d = S_WB_ACK;
            S_WB_ACK:   if (dma_wack_valid) state_d = S_IDLE;
            S_ERROR:    if (!cfg_enable) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q      <= '0;
            tail_q      <= '0;
            cur_idx_q   <= '0;
            desc_addr_q <= '0;
            buf_addr_q  <= '0;
            word1_q     <= '0;
            irq_q       <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (tail_wr) tail_q <= tail_val;
            if (state_q == S_IDLE) begin
                cur_idx_q   <= head_q;
                desc_addr_q <= cfg_ring_base + ADDR_W'({head_q, {SLOT_SHIFT{1'b0}}});
            end
            if (state_q == S_DESC_W0 && dma_rd_valid) buf_addr_q <= dma_rd_data[ADDR_W-1:0];
            if (state_q == S_DESC_W1 && dma_rd_valid) word1_q <= dma_rd_data;
            if (state_q == S_WB_ACK && dma_wack_valid && cfg_enable) begin
                head_q <= nxt_idx;
                irq_q  <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        dma_req_valid = 1'b0;
        dma_req_write = 1'b0;
        dma_req_addr  = desc_addr_q;
        dma_req_len   = 16'(DESC_BYTES);
        dma_req_wdata = '0;
        dma_rd_ready  = 1'b0;
        tx_valid      = 1'b0;
        unique case (state_q)
            S_DESC_REQ: dma_req_valid = 1'b1;
            S_DESC_W0, S_DESC_W1: dma_rd_ready = 1'b1;
            S_BUF_REQ: begin
                dma_req_valid = 1'b1;
                dma_req_addr  = buf_addr_q;
                dma_req_len   = 16'(buf_size);
            end
            S_STREAM: begin
                dma_rd_ready = tx_ready;
                tx_valid     = dma_rd_valid;
            end
            S_WB_REQ: begin
                dma_req_valid = 1'b1;
                dma_req_write = 1'b1;
                if (cfg_hwb_en) begin
                    dma_req_addr  = cfg_hwb_addr;
                    dma_req_len   = 16'(HWB_BYTES);
                    dma_req_wdata = 128'(nxt_idx);
                end else begin
                    dma_req_wdata = {64'(TYPE_DONE) << TYPE_LSB, 64'h0};
                end
            end
            default: ;
        endcase
    end

    assign tx_data  = dma_rd_data;
    assign tx_keep  = beat_keep;
    assign tx_last  = beat_last;
    assign head_idx = head_q;
    assign irq      = irq_q;
    assign err      = (state_q == S_ERROR);

    // R8: head moves only in the cycle after a write acknowledge
    a_r8_head_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (head_q != $past(head_q)) |-> $past(dma_wack_valid));
    // R8 / R10: interrupt only follows an acknowledge seen while enabled
    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(dma_wack_valid && cfg_enable));
    // R3: a halted queue is silent on both ports
    a_r3_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!dma_req_valid && !tx_valid));
    // R2: a pending request holds steady
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_valid && !dma_req_ready) |=>
            (dma_req_valid && $stable(dma_req_addr) && $stable(dma_req_write)));
endmodule

// File: tb/txring_engine_test.sv
`timescale 1ns/1ps
module txring_engine_test;
    localparam int AW = 48;
    localparam int IW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b0;
    logic [AW-1:0] cfg_ring_base = 48'h100;
    logic [IW-1:0] cfg_ring_len = 8'd8;
    logic cfg_hwb_en = 1'b0;
    logic [AW-1:0] cfg_hwb_addr = 48'h7F0;
    logic tail_wr = 1'b0;
    logic [IW-1:0] tail_val = '0;
    logic [IW-1:0] head_idx;
    logic dma_req_valid, dma_req_write, dma_rd_ready;
    logic dma_req_ready;
    logic [AW-1:0] dma_req_addr;
    logic [15:0] dma_req_len;
    logic [127:0] dma_req_wdata;
    logic dma_rd_valid;
    logic [63:0] dma_rd_data;
    logic dma_wack_valid;
    logic tx_valid, tx_last, irq, err;
    logic tx_ready;
    logic [63:0] tx_data;
    logic [7:0] tx_keep;

    always #4 clk = ~clk;

    txring_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_ring_base(cfg_ring_base),
        .cfg_ring_len(cfg_ring_len), .cfg_hwb_en(cfg_hwb_en), .cfg_hwb_addr(cfg_hwb_addr),
        .tail_wr(tail_wr), .tail_val(tail_val), .head_idx(head_idx),
        .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
        .dma_req_write(dma_req_write), .dma_req_addr(dma_req_addr), .dma_req_len(dma_req_len),
        .dma_req_wdata(dma_req_wdata), .dma_rd_valid(dma_rd_valid), .dma_rd_ready(dma_rd_ready),
        .dma_rd_data(dma_rd_data), .dma_wack_valid(dma_wack_valid), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_keep(tx_keep), .tx_last(tx_last),
        .irq(irq), .err(err));

    logic [7:0] hmem [0:2047];
    logic [AW-1:0] req_addr [0:63];
    logic [15:0] req_len [0:63];
    logic req_wr [0:63];
    logic [127:0] req_wdata [0:63];
    logic [IW-1:0] req_head [0:63];
    logic [7:0] tx_bytes [0:255];
    int req_n = 0, wr_n = 0, tx_n = 0, frame_n = 0, irq_n = 0;
    logic [7:0] last_keep = '0;
    int rd_left = 0, rd_ptr = 0, wack_dly = 0, cyc = 0;
    bit tx_stall = 0, req_slow = 0;
    int checks = 0, errors = 0;

    function automatic logic [63:0] beat_at(int p);
        logic [63:0] b;
        for (int k = 0; k < 8; k++) b[8*k +: 8] = hmem[(p + k) & 2047];
        return b;
    endfunction

    // DMA responder and transmit sink
    initial begin
        dma_rd_valid = 1'b0; dma_rd_data = '0; dma_wack_valid = 1'b0;
        tx_ready = 1'b1; dma_req_ready = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            dma_wack_valid = 1'b0;
            if (wack_dly != 0) begin
                wack_dly--;
                if (wack_dly == 0) dma_wack_valid = 1'b1;
            end
            if (rd_left != 0) begin
                dma_rd_valid = 1'b1; dma_rd_data = beat_at(rd_ptr);
            end else dma_rd_valid = 1'b0;
            tx_ready = !(tx_stall && (cyc % 3 == 1));
            dma_req_ready = !(req_slow && (cyc % 2 == 0));
            #2;
            if (irq) irq_n++;
            if (dma_req_valid && dma_req_ready && req_n < 64) begin
                req_addr[req_n] = dma_req_addr; req_len[req_n] = dma_req_len;
                req_wr[req_n] = dma_req_write; req_wdata[req_n] = dma_req_wdata;
                req_head[req_n] = head_idx;
                req_n++;
                if (!dma_req_write) begin
                    rd_ptr = int'(dma_req_addr[10:0]);
                    rd_left = (int'(dma_req_len) + 7) / 8;
                end else begin
                    wr_n++; wack_dly = 2;
                end
            end
            if (dma_rd_valid && dma_rd_ready) begin
                rd_ptr += 8; rd_left--;
            end
            if (tx_valid && tx_ready) begin
                for (int k = 0; k < 8; k++)
                    if (tx_keep[k] && tx_n < 256) begin
                        tx_bytes[tx_n] = tx_data[8*k +: 8]; tx_n++;
                    end
                if (tx_last) begin frame_n++; last_keep = tx_keep; end
            end
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input int idx, input int bufa, input int typ, input bit eop, input int size);
        logic [63:0] w0, w1;
        w0 = 64'(bufa);
        w1 = 64'(typ) | (64'(eop) << 4) | (64'(size) << 34);
        for (int k = 0; k < 8; k++) begin
            hmem[(256 + idx*16 + k) & 2047] = w0[8*k +: 8];
            hmem[(256 + idx*16 + 8 + k) & 2047] = w1[8*k +: 8];
        end
    endtask

    task automatic fill(input int a, input int n, input int seed);
        for (int k = 0; k < n; k++) hmem[(a + k) & 2047] = 8'(seed * 7 + k * 13 + 1);
    endtask

    task automatic write_tail(input int v);
        @(negedge clk); tail_wr = 1'b1; tail_val = IW'(v);
        @(negedge clk); tail_wr = 1'b0;
    endtask

    task automatic wait_irq(input int target);
        for (int i = 0; i < 600; i++) begin
            if (irq_n >= target) break;
            @(negedge clk); #3;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #3;
    endtask

    task automatic frame_match(input string tag, input int start, input int bufa, input int n);
        bit ok = 1;
        for (int k = 0; k < n; k++) if (tx_bytes[start + k] !== hmem[(bufa + k) & 2047]) ok = 0;
        chk(tag, 128'(ok), 128'(1));
    endtask

    task automatic t_reset;
        #3;
        chk("R1 head", 128'(head_idx), 0);
        chk("R1 req", 128'(dma_req_valid), 0);
        chk("R1 tx", 128'(tx_valid), 0);
        chk("R1 irq", 128'(irq), 0);
        chk("R1 err", 128'(err), 0);
    endtask

    task automatic t_single_desc_mode;
        int r0 = req_n, t0 = tx_n, f0 = frame_n, i0 = irq_n;
        put_desc(0, 'h400, 0, 1, 20); fill('h400, 20, 1);
        cfg_enable = 1'b1; req_slow = 1;
        write_tail(1);
        wait_irq(i0 + 1); idle(4);
        req_slow = 0;
        chk("R2 fetch addr", 128'(req_addr[r0]), 128'h100);
        chk("R2 fetch len", 128'(req_len[r0]), 16);
        chk("R2 fetch is read", 128'(req_wr[r0]), 0);
        chk("R5 buf addr", 128'(req_addr[r0+1]), 128'h400);
        chk("R5 byte count", 128'(tx_n - t0), 20);
        chk("R5 one frame", 128'(frame_n - f0), 1);
        chk("R5 last keep", 128'(last_keep), 128'h0F);
        frame_match("R5 payload", t0, 'h400, 20);
        chk("R6 wb addr", 128'(req_addr[r0+2]), 128'h100);
        chk("R6 wb len", 128'(req_len[r0+2]), 16);
        chk("R6 wb data", req_wdata[r0+2], {64'hF, 64'h0});
        chk("R8 head before ack", 128'(req_head[r0+2]), 0);
        chk("R8 head after", 128'(head_idx), 1);
        chk("R8 irq count", 128'(irq_n - i0), 1);
    endtask

    task automatic t_hwb_wrap_latched_tail;
        int r0 = req_n, t0 = tx_n, f0 = frame_n, i0 = irq_n;
        cfg_ring_len = 8'd3; cfg_hwb_en = 1'b1; tx_stall = 1;
        put_desc(1, 'h500, 0, 1, 8); fill('h500, 8, 2);
        put_desc(2, 'h600, 0, 1, 13); fill('h600, 13, 3);
        write_tail(2);
        idle(6);
        write_tail(0);
        wait_irq(i0 + 2); idle(20);
        tx_stall = 0;
        chk("R9 frames", 128'(frame_n - f0), 2);
        chk("R9 requests", 128'(req_n - r0), 6);
        frame_match("R5 payload a", t0, 'h500, 8);
        frame_match("R5 payload b", t0 + 8, 'h600, 13);
        chk("R5 keep partial", 128'(last_keep), 128'h1F);
        chk("R7 wb addr", 128'(req_addr[r0+2]), 128'h7F0);
        chk("R7 wb len", 128'(req_len[r0+2]), 4);
        chk("R7 wb data", 128'(req_wdata[r0+2][31:0]), 2);
        chk("R7 wb data wrap", 128'(req_wdata[r0+5][31:0]), 0);
        chk("R8 head before 2nd ack", 128'(req_head[r0+5]), 2);
        chk("R8 head wrapped", 128'(head_idx), 0);
        chk("R8 irq count", 128'(irq_n - i0), 2);
        cfg_hwb_en = 1'b0;
    endtask

    task automatic t_zero_size;
        int r0 = req_n, t0 = tx_n, f0 = frame_n, i0 = irq_n;
        put_desc(0, 'h700, 0, 1, 0);
        write_tail(1);
        wait_irq(i0 + 1); idle(4);
        chk("R12 no bytes", 128'(tx_n - t0), 0);
        chk("R12 no frame", 128'(frame_n - f0), 0);
        chk("R12 wb is write", 128'(req_wr[r0+1]), 1);
        chk("R12 head", 128'(head_idx), 1);
    endtask

    task automatic t_errors;
        int r0 = req_n, t0 = tx_n;
        put_desc(1, 'h480, 3, 1, 8);
        write_tail(2);
        idle(20);
        chk("R3 err set", 128'(err), 1);
        chk("R3 head kept", 128'(head_idx), 1);
        chk("R3 only fetch", 128'(req_n - r0), 1);
        chk("R3 no tx", 128'(tx_n - t0), 0);
        cfg_enable = 1'b0; idle(2);
        chk("R11 err cleared", 128'(err), 0);
        put_desc(1, 'h480, 0, 0, 8);
        cfg_enable = 1'b1; idle(20);
        chk("R4 err no eop", 128'(err), 1);
        chk("R4 head kept", 128'(head_idx), 1);
        cfg_enable = 1'b0; idle(2);
        chk("R11 err cleared again", 128'(err), 0);
    endtask

    task automatic t_disabled;
        int r0 = req_n, w0 = wr_n, i0, t0;
        put_desc(1, 'h480, 0, 1, 5); fill('h480, 5, 4);
        idle(20);
        chk("R10 no fetch disabled", 128'(req_n - r0), 0);
        i0 = irq_n;
        cfg_enable = 1'b1;
        for (int i = 0; i < 200; i++) begin
            if (wr_n > w0) break;
            @(negedge clk); #3;
        end
        cfg_enable = 1'b0;
        idle(10);
        chk("R10 head held", 128'(head_idx), 1);
        chk("R10 no irq", 128'(irq_n - i0), 0);
        t0 = tx_n;
        cfg_enable = 1'b1;
        wait_irq(i0 + 1); idle(4);
        chk("R9 redo frame", 128'(tx_n - t0), 5);
        chk("R8 head after redo", 128'(head_idx), 2);
    endtask

    initial begin
        for (int k = 0; k < 2048; k++) hmem[k] = '0;
        repeat (5) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_single_desc_mode;
        t_hwb_wrap_latched_tail;
        t_zero_size;
        t_errors;
        t_disabled;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule